// File: doc/BRIEF.md
# Dual Aligned Selectable Clock Divider

This block takes one fast input clock and derives two divided clocks from it. Output A runs at one half or one quarter of the input rate. Output B runs at one quarter or one sixth of the input rate. Each output has its own ratio select, and both dividers step from a single shared phase counter. Because of that counter, the edges the two outputs have in common always land on the same input clock edge.

A run control, sampled on the falling input edge, freezes both dividers or lets them continue. Because it is sampled on the falling edge, a freeze or resume never cuts an internal clock period short. A master reset clears all divider state at once. Its release is synchronised to the input clock, so several copies of the block that share one reset come out of it in phase. A ratio select that changes while the block is running waits for the next common boundary of the two outputs before it takes effect, so no divided period is ever left irregular.

Top module: `lockstep_clk_div`

## Requirements
- R1: With `sel_a` = 0, `out_a` is the input clock divided by 2. With `sel_a` = 1, it is divided by 4. The duty cycle is 50% in both cases: high for 1 or 2 input cycles, then low for the same number.
- R2: With `sel_b` = 0, `out_b` is the input clock divided by 4. With `sel_b` = 1, it is divided by 6. The duty cycle is 50%: high for 2 or 3 input cycles, then low for the same number.
- R3: While `master_rst` is 1, both outputs are 0. They fall as soon as `master_rst` rises, without waiting for a clock edge.
- R4: After `master_rst` falls, with `freeze` at 0, both outputs stay 0 through the next two rising edges of `clk_in`. Both rise together on the third rising edge.
- R5: `freeze` is captured on the falling edge of `clk_in`. While the captured value is 1, both outputs and the divider phase hold at every rising edge. Once it returns to 0, division continues from the held phase.
- R6: Outputs change only on rising edges where the captured `freeze` is 0. No high or low interval is shorter than half the selected period.
- R7: Both dividers share one phase counter with a period of 12 input cycles. At every wrap of this counter, `out_a` and `out_b` rise on the same edge. With ratios 2 and 6, every rise of `out_b` coincides with a rise of `out_a`.
- R8: A new value on `sel_a` or `sel_b` is adopted only on the edge where the shared phase wraps. Before that edge, the outputs keep the ratio that was already active.
- R9: Two instances that share `clk_in` and `master_rst` produce identical outputs after a common reset, even if they had drifted apart before it.
- R10: With all inputs at 0 during reset, both outputs read 0, and the frozen state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| master_rst | input | 1 | Master reset, active high. Asserts asynchronously and is released synchronously. |
| freeze | input | 1 | Run control, captured on the falling edge. 1 holds both dividers. |
| sel_a | input | 1 | Ratio select for output A: 0 divides by 2, 1 divides by 4 |
| sel_b | input | 1 | Ratio select for output B: 0 divides by 4, 1 divides by 6 |
| out_a | output | 1 | Divided clock A (registered) |
| out_b | output | 1 | Divided clock B (registered) |

## Verification
The assertions assume three things about the inputs. First, `freeze` is stable around each falling edge of `clk_in`. Second, both selects are stable around each rising edge. Third, `master_rst` never changes at a clock edge, so its synchronous release can be counted in whole edges. The stimulus meets all three by driving every input 5 ns after a rising edge, a quarter period clear of both edges. A behavioural model of the phase, the selects and the frozen state predicts each output on every cycle. A second instance, whose run control is driven separately, checks that a common reset brings two drifted copies back into alignment.

// File: rtl/ldiv_pkg.sv
`timescale 1ns/1ps
package ldiv_pkg;

  function automatic int gcd_f(input int x, input int y);
    int p;
    int q;
    int t;
    p = x;
    q = y;
    while (q != 0) begin
      t = p % q;
      p = q;
      q = t;
    end
    return p;
  endfunction

  function automatic int lcm_f(input int x, input int y);
    return (x / gcd_f(x, y)) * y;
  endfunction

endpackage

// File: rtl/ldiv_rst_sync.sv
`timescale 1ns/1ps
module ldiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_in,
  input  logic arst,
  output logic rst_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_in or posedge arst) begin
    if (arst) shift_q <= '0;
    else      shift_q <= shift_d;
  end

  assign rst_n = shift_q[STAGES-1];
endmodule

// File: rtl/ldiv_freeze_cap.sv
`timescale 1ns/1ps
module ldiv_freeze_cap (
  input  logic clk_in,
  input  logic rst_n,
  input  logic freeze,
  output logic run_en
);
  logic frz_q;

  // Captured on the falling edge, so the run decision settles while clk is low
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) frz_q <= 1'b0;
    else        frz_q <= freeze;
  end

  assign run_en = rst_n & ~frz_q;
endmodule

// File: rtl/ldiv_phase.sv
`timescale 1ns/1ps
module ldiv_phase #(
  parameter int PERIOD = 12,
  localparam int PW = $clog2(PERIOD)
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic          run_en,
  output logic [PW-1:0] ph_nxt,
  output logic          wrap
);
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] ph_q;

  always_comb begin
    wrap   = run_en && (ph_q == LAST);
    ph_nxt = ph_q;
    if (run_en) begin
      if (ph_q == LAST) ph_nxt = '0;
      else              ph_nxt = ph_q + 1'b1;
    end
  end

  // Reset to the last phase: every ratio is low there, and the first step rises
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) ph_q <= LAST;
    else        ph_q <= ph_nxt;
  end
endmodule

// File: rtl/ldiv_output.sv
`timescale 1ns/1ps
module ldiv_output #(
  parameter int R_LO = 2,
  parameter int R_HI = 4,
  parameter int PW   = 4
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          wrap,
  input  logic [PW-1:0] ph_nxt,
  input  logic          sel,
  output logic          sel_act,
  output logic          clk_out
);
  logic sel_q;
  logic sel_d;
  logic out_q;
  logic out_d;
  logic lvl_lo;
  logic lvl_hi;
  int   ph_i;

  always_comb begin
    ph_i   = int'(ph_nxt);
    lvl_lo = (ph_i % R_LO) < (R_LO / 2);
    lvl_hi = (ph_i % R_HI) < (R_HI / 2);
    // A new ratio is only loaded at the common phase wrap
    sel_d  = wrap ? sel : sel_q;
    out_d  = out_q;
    if (run_en) out_d = sel_d ? lvl_hi : lvl_lo;
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      out_q <= out_d;
    end
  end

  assign sel_act = sel_q;
  assign clk_out = out_q;
endmodule

// File: rtl/lockstep_clk_div.sv
`timescale 1ns/1ps
module lockstep_clk_div #(
  parameter int A_LO        = 2,
  parameter int A_HI        = 4,
  parameter int B_LO        = 4,
  parameter int B_HI        = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_in,
  input  logic master_rst,
  input  logic freeze,
  input  logic sel_a,
  input  logic sel_b,
  output logic out_a,
  output logic out_b
);
  import ldiv_pkg::*;

  localparam int PERIOD = lcm_f(lcm_f(A_LO, A_HI), lcm_f(B_LO, B_HI));
  localparam int PW     = $clog2(PERIOD);
  localparam int NCH    = 2;
  localparam int RLO [NCH] = '{A_LO, B_LO};
  localparam int RHI [NCH] = '{A_HI, B_HI};

  logic           rst_n_sync;
  logic           run_en;
  logic           wrap;
  logic [PW-1:0]  ph_nxt;
  logic [NCH-1:0] sel_in_v;
  logic [NCH-1:0] sel_act_v;
  logic [NCH-1:0] out_v;

  ldiv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_in (clk_in),
    .arst   (master_rst),
    .rst_n  (rst_n_sync)
  );

  ldiv_freeze_cap u_frz (
    .clk_in (clk_in),
    .rst_n  (rst_n_sync),
    .freeze (freeze),
    .run_en (run_en)
  );

  ldiv_phase #(.PERIOD(PERIOD)) u_ph (
    .clk_in (clk_in),
    .rst_n  (rst_n_sync),
    .run_en (run_en),
    .ph_nxt (ph_nxt),
    .wrap   (wrap)
  );

  assign sel_in_v = {sel_b, sel_a};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ldiv_output #(.R_LO(RLO[g]), .R_HI(RHI[g]), .PW(PW)) u_out (
      .clk_in  (clk_in),
      .rst_n   (rst_n_sync),
      .run_en  (run_en),
      .wrap    (wrap),
      .ph_nxt  (ph_nxt),
      .sel     (sel_in_v[g]),
      .sel_act (sel_act_v[g]),
      .clk_out (out_v[g])
    );
  end

  assign out_a = out_v[0];
  assign out_b = out_v[1];
endmodule

// File: rtl/ldiv_chk.sv
`timescale 1ns/1ps
module ldiv_chk (
  input logic       clk_in,
  input logic       master_rst,
  input logic       rst_n,
  input logic       run,
  input logic       wrap,
  input logic       sel_a,
  input logic       sel_b,
  input logic [1:0] sel_act,
  input logic       out_a,
  input logic       out_b
);
  always @(posedge clk_in) begin
    if (master_rst === 1'b1) begin
      assert_reset_low_R3: assert (!out_a && !out_b)
        else $error("outputs not low under master reset");
    end
  end

  assert_release_low_R4: assert property (@(posedge clk_in) disable iff (master_rst)
    $rose(rst_n) |-> (!out_a && !out_b));

  assert_hold_R5: assert property (@(posedge clk_in) disable iff (!rst_n)
    !run |=> ($stable(out_a) && $stable(out_b)));

  assert_edge_gated_R6: assert property (@(posedge clk_in) disable iff (!rst_n)
    (!$stable(out_a) || !$stable(out_b)) |-> $past(run));

  assert_wrap_rise_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
    wrap |=> (out_a && out_b));

  assert_sel_hold_R8: assert property (@(posedge clk_in) disable iff (!rst_n)
    !wrap |=> $stable(sel_act));

  assert_sel_load_R8: assert property (@(posedge clk_in) disable iff (!rst_n)
    wrap |=> (sel_act == $past({sel_b, sel_a})));
endmodule

bind lockstep_clk_div ldiv_chk u_ldiv_chk (
  .clk_in     (clk_in),
  .master_rst (master_rst),
  .rst_n      (rst_n_sync),
  .run        (run_en),
  .wrap       (wrap),
  .sel_a      (sel_a),
  .sel_b      (sel_b),
  .sel_act    (sel_act_v),
  .out_a      (out_a),
  .out_b      (out_b)
);

// File: tb/test_lockstep_clk_div.sv
`timescale 1ns/1ps
module test_lockstep_clk_div;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic master_rst, freeze, freeze2, sel_a, sel_b;
  logic out_a, out_b, pout_a, pout_b;

  int   n_chk = 0;
  int   n_fail = 0;
  int   m_ph, rel, cnt_a, cnt_b;
  logic m_sa, m_sb, m_a, m_b, m_frz, prv_a, prv_b;
  bit   exact_on, runt_on, peer_on, finished;

  lockstep_clk_div i_lockstep_clk_div (
    .clk_in(clk), .master_rst(master_rst), .freeze(freeze),
    .sel_a(sel_a), .sel_b(sel_b), .out_a(out_a), .out_b(out_b));

  lockstep_clk_div i_lockstep_clk_div_peer (
    .clk_in(clk), .master_rst(master_rst), .freeze(freeze2),
    .sel_a(sel_a), .sel_b(sel_b), .out_a(pout_a), .out_b(pout_b));

  function automatic int rat_a(input logic s);
    return s ? 4 : 2;
  endfunction

  function automatic int rat_b(input logic s);
    return s ? 6 : 4;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    rel = 0; m_ph = 11; m_sa = 1'b0; m_sb = 1'b0;
    m_a = 1'b0; m_b = 1'b0; m_frz = 1'b0;
  endtask

  // Falling-edge capture of the run control
  always @(negedge clk) begin
    m_frz = (master_rst || rel < 2) ? 1'b0 : freeze;
  end

  task automatic model_edge();
    int nph;
    if (master_rst) begin
      model_clear();
    end else begin
      if (rel >= 2 && !m_frz) begin
        nph = (m_ph + 1) % 12;
        if (m_ph == 11) begin
          m_sa = sel_a;
          m_sb = sel_b;
        end
        m_a  = (nph % rat_a(m_sa)) < (rat_a(m_sa) / 2);
        m_b  = (nph % rat_b(m_sb)) < (rat_b(m_sb) / 2);
        m_ph = nph;
      end
      if (rel < 2) rel++;
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
    model_edge();
    check(out_a === m_a, "R1 R5 R8 out_a vs model", out_a, m_a);
    check(out_b === m_b, "R2 R5 R8 out_b vs model", out_b, m_b);
    if (m_ph == 0 && rel >= 2 && !master_rst)
      check(out_a && out_b, "R7 common rise at wrap", {out_a, out_b}, 3);
    if (peer_on)
      check(pout_a === out_a && pout_b === out_b, "R9 peer aligned",
            {pout_a, pout_b}, {out_a, out_b});
    cnt_a++;
    if (out_a !== prv_a) begin
      if (exact_on) check(cnt_a == rat_a(m_sa) / 2, "R1 half period A", cnt_a, rat_a(m_sa) / 2);
      if (runt_on)  check(cnt_a >= rat_a(m_sa) / 2, "R6 no short pulse A", cnt_a, rat_a(m_sa) / 2);
      cnt_a = 0;
    end
    prv_a = out_a;
    cnt_b++;
    if (out_b !== prv_b) begin
      if (exact_on) check(cnt_b == rat_b(m_sb) / 2, "R2 half period B", cnt_b, rat_b(m_sb) / 2);
      if (runt_on)  check(cnt_b >= rat_b(m_sb) / 2, "R6 no short pulse B", cnt_b, rat_b(m_sb) / 2);
      cnt_b = 0;
    end
    prv_b = out_b;
  endtask

  task automatic hit_reset();
    master_rst = 1'b1;
    model_clear();
    #1;
    check(!out_a && !out_b, "R3 async reset clears outputs", {out_a, out_b}, 0);
    check(!pout_a && !pout_b, "R3 async reset clears peer", {pout_a, pout_b}, 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic ha, hb;
    master_rst = 1'b1; freeze = 1'b0; freeze2 = 1'b0; sel_a = 1'b0; sel_b = 1'b0;
    model_clear();
    cnt_a = 0; cnt_b = 0; prv_a = 1'b0; prv_b = 1'b0;
    exact_on = 0; runt_on = 0; peer_on = 0; finished = 0;

    repeat (3) step();
    check(!out_a && !out_b, "R10 reset state low", {out_a, out_b}, 0);

    master_rst = 1'b0;
    step(); step();
    check(!out_a && !out_b, "R4 low after two release edges", {out_a, out_b}, 0);
    step();
    check(out_a && out_b, "R4 joint rise on third edge", {out_a, out_b}, 3);
    peer_on = 1;

    for (int c = 0; c < 4; c++) begin
      sel_a = c[0];
      sel_b = c[1];
      repeat (26) step();
      exact_on = 1;
      repeat (24) step();
      exact_on = 0;
    end

    // Run control: hold and resume at several phases
    sel_a = 1'b1; sel_b = 1'b1;
    repeat (26) step();
    runt_on = 1;
    for (int k = 0; k < 4; k++) begin
      repeat (k + 3) step();
      freeze = 1'b1; freeze2 = 1'b1;
      step();
      ha = out_a; hb = out_b;
      for (int j = 0; j < 5; j++) begin
        step();
        check(out_a === ha && out_b === hb, "R5 outputs held while frozen",
              {out_a, out_b}, {ha, hb});
      end
      freeze = 1'b0; freeze2 = 1'b0;
    end
    repeat (30) step();
    runt_on = 0;

    // Drift the peer, then realign both with a shared reset
    peer_on = 0;
    freeze2 = 1'b1;
    repeat (5) step();
    freeze2 = 1'b0;
    repeat (3) step();
    while (out_a !== 1'b1) step();
    hit_reset();
    step(); step();
    master_rst = 1'b0;
    peer_on = 1;
    repeat (40) step();
    sel_a = 1'b0; sel_b = 1'b1;
    repeat (40) step();

    finished = 1;
    summary();
    $finish;
  end
endmodule